// File: doc/BRIEF.md
# Wake-Up Receiver Duty-Cycle Controller

This block holds the digital control of a two-mode wake-up receiver. While it listens for a start sequence, it powers the analog front end for only a short window inside each slow bit period. On the last clock tick of that window it takes one sample from the 1-bit envelope detector. Each sample is shifted into a history register, which is compared against a programmable start pattern.

When the last eight samples equal the pattern, duty cycling stops. The front end is then held on continuously and the identifier decoder is enabled, so the remainder of the packet can arrive at a much higher rate. The controller goes back to windowed listening when the decoder reports completion or failure, or when a tick-based timeout expires. On that return it clears the sample history.

A free-running divider turns the system clock into a 1 MHz tick. With the default division of 24, a 24 MHz reference gives that 1 MHz tick. All timing values are counted in ticks and can be changed through a small write port. A test input forces identification mode so that the decoder can be exercised on its own.

Top module: `wkc_dutycycle_ctrl`

## Requirements
- R1: After reset, `dec_en` is low and `fe_en` is high, because a new bit period starts with its active window. The reset pattern is 8'hAC, the period is 1000 ticks, the window is 6 ticks and the timeout is 2000 ticks.
- R2: In monitoring mode, `fe_en` is high for exactly window×TICK_DIV clock cycles. Successive rising edges of `fe_en` are period×TICK_DIV cycles apart.
- R3: Exactly one sample of `det_in` is taken per period, at the clock edge of the window's last tick, which is the edge where `fe_en` falls. Values of `det_in` outside the window are ignored. Samples enter the history at bit 0 and shift toward bit 7, so the first bit received is compared with pattern bit 7.
- R4: If the new history equals the pattern, identification mode is entered on the same edge as that final sample. `fe_en` then stays high without a gap, and `dec_en` rises.
- R5: Throughout identification mode, `fe_en` and `dec_en` are both held high.
- R6: If no decoder result arrives, identification mode ends exactly timeout×TICK_DIV cycles after it began. On that same edge, monitoring restarts with a new active window, so `fe_en` stays high.
- R7: A `dec_done` or `dec_fail` pulse during identification mode returns the block to monitoring on the next clock edge.
- R8: The sample history is cleared whenever the block is not monitoring. A match then needs eight fresh samples, and this holds even for an all-zero pattern.
- R9: While `force_id` is high, `fe_en` and `dec_en` are high from the same cycle, with no timeout. After release, monitoring starts with an empty history.
- R10: When `cfg_we` is high, `cfg_wdata` is written to the register selected by `cfg_addr`: 0 = pattern (bits 7:0), 1 = period, 2 = window, 3 = timeout, all in ticks. The new value governs all later behaviour.
- R11: Eight samples that do not equal the pattern leave the block in monitoring mode, with `dec_en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (reference clock) |
| rst_n | input | 1 | Active-low asynchronous reset |
| force_id | input | 1 | Test: force identification mode |
| det_in | input | 1 | Envelope detector 1-bit output |
| dec_done | input | 1 | Identifier decoder finished |
| dec_fail | input | 1 | Identifier decoder rejected packet |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | TW | Configuration write data |
| fe_en | output | 1 | Front-end power enable |
| dec_en | output | 1 | Identifier decoder enable |

## Verification
Each result has a fixed due cycle, and the bench samples at that cycle.

- **Pulse shape.** Widths and spacings are counted in clock cycles between falling-edge samples. They must equal window×TICK_DIV and period×TICK_DIV exactly, and a scoreboard queue holds each expected pulse until the monitor observes it.
- **Entering identification mode.** A match is due on the sampling edge itself. The bench therefore checks `dec_en` at the first falling edge after the window's last tick.
- **Leaving identification mode.** A decoder result is due one cycle after the pulse. The timeout is checked by counting the `dec_en`-high cycles against timeout×TICK_DIV.
- **Forced mode.** Forced outputs are checked in the same cycle as `force_id`.

// File: rtl/wkc_pkg.sv
package wkc_pkg;
   typedef enum logic {
      MODE_MON = 1'b0,
      MODE_ID  = 1'b1
   } wkc_mode_e;

   localparam logic [1:0] CFG_PATTERN = 2'd0;
   localparam logic [1:0] CFG_PERIOD  = 2'd1;
   localparam logic [1:0] CFG_WINDOW  = 2'd2;
   localparam logic [1:0] CFG_TIMEOUT = 2'd3;
endpackage

// File: rtl/wkc_tick_gen.sv
module wkc_tick_gen #(
   parameter int DIV = 24
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (DIV < 1) begin : g_bad
         $error("wkc_tick_gen: DIV must be at least 1");
      end

      if (DIV == 1) begin : g_pass
         logic unused_tick_in;
         assign unused_tick_in = clk ^ rst_n;
         assign tick = 1'b1;
      end else begin : g_cnt
         localparam int DW = $clog2(DIV);
         localparam logic [DW-1:0] LAST = DW'(DIV - 1);
         logic [DW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (cnt_q == LAST)
               cnt_q <= '0;
            else
               cnt_q <= cnt_q + DW'(1);
         end

         assign tick = (cnt_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/wkc_cfg_regs.sv
module wkc_cfg_regs
   import wkc_pkg::*;
#(
   parameter int             PW      = 8,
   parameter int             TW      = 16,
   parameter logic [PW-1:0]  PAT_RST = 8'hAC,
   parameter int             PER_RST = 1000,
   parameter int             WIN_RST = 6,
   parameter int             TO_RST  = 2000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [1:0]    addr,
   input  logic [TW-1:0] wdata,
   output logic [PW-1:0] pattern,
   output logic [TW-1:0] period,
   output logic [TW-1:0] window,
   output logic [TW-1:0] timeout
);
   generate
      if (PW > TW) begin : g_bad_w
         $error("wkc_cfg_regs: pattern wider than data word");
      end
      if (PER_RST >= (2 ** TW) || TO_RST >= (2 ** TW)) begin : g_bad_rst
         $error("wkc_cfg_regs: reset value does not fit TW");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pattern <= PAT_RST;
         period  <= TW'(PER_RST);
         window  <= TW'(WIN_RST);
         timeout <= TW'(TO_RST);
      end else if (we) begin
         case (addr)
            CFG_PATTERN: pattern <= wdata[PW-1:0];
            CFG_PERIOD:  period  <= wdata;
            CFG_WINDOW:  window  <= wdata;
            default:     timeout <= wdata;
         endcase
      end
   end
endmodule

// File: rtl/wkc_start_matcher.sv
module wkc_start_matcher #(
   parameter int PW = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        flush,
   input  logic                        shift,
   input  logic                        bit_in,
   input  logic [PW-1:0]               pattern,
   output logic                        hit,
   output logic [$clog2(PW+1)-1:0]     fill
);
   localparam int CW = $clog2(PW + 1);
   localparam logic [CW-1:0] FULL   = CW'(PW);
   localparam logic [CW-1:0] NEARLY = CW'(PW - 1);

   generate
      if (PW < 2) begin : g_bad
         $error("wkc_start_matcher: pattern must be at least 2 bits");
      end
   endgenerate

   logic [PW-1:0] hist_q;
   logic [PW-1:0] hist_nx;
   logic [CW-1:0] fill_q;

   assign hist_nx = {hist_q[PW-2:0], bit_in};
   assign hit     = shift && !flush && (fill_q >= NEARLY) && (hist_nx == pattern);
   assign fill    = fill_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q <= '0;
         fill_q <= '0;
      end else if (flush) begin
         hist_q <= '0;
         fill_q <= '0;
      end else if (shift) begin
         hist_q <= hist_nx;
         if (fill_q != FULL)
            fill_q <= fill_q + CW'(1);
      end
   end
endmodule

// File: rtl/wkc_dutycycle_ctrl.sv
module wkc_dutycycle_ctrl
   import wkc_pkg::*;
#(
   parameter int             TICK_DIV = 24,
   parameter int             PW       = 8,
   parameter int             TW       = 16,
   parameter logic [PW-1:0]  PAT_RST  = 8'hAC,
   parameter int             PER_RST  = 1000,
   parameter int             WIN_RST  = 6,
   parameter int             TO_RST   = 2000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          force_id,
   input  logic          det_in,
   input  logic          dec_done,
   input  logic          dec_fail,
   input  logic          cfg_we,
   input  logic [1:0]    cfg_addr,
   input  logic [TW-1:0] cfg_wdata,
   output logic          fe_en,
   output logic          dec_en
);
   localparam logic [TW-1:0] ONE = TW'(1);

   generate
      if (WIN_RST < 1 || WIN_RST >= PER_RST) begin : g_bad_win
         $error("wkc_dutycycle_ctrl: window must be 1..period-1");
      end
      if (TO_RST < 1) begin : g_bad_to
         $error("wkc_dutycycle_ctrl: timeout must be nonzero");
      end
   endgenerate

   logic          tick;
   logic [PW-1:0] pattern;
   logic [TW-1:0] period, window, timeout;
   logic          hit, shift, flush;
   logic [$clog2(PW+1)-1:0] fill;

   wkc_mode_e     state_q;
   logic [TW-1:0] pos_q;
   logic [TW-1:0] tcnt_q;

   logic mon, in_win, at_sample, wrap, expire, leave;

   wkc_tick_gen #(.DIV(TICK_DIV)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick)
   );

   wkc_cfg_regs #(
      .PW(PW), .TW(TW), .PAT_RST(PAT_RST),
      .PER_RST(PER_RST), .WIN_RST(WIN_RST), .TO_RST(TO_RST)
   ) u_cfg (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (cfg_we),
      .addr   (cfg_addr),
      .wdata  (cfg_wdata),
      .pattern(pattern),
      .period (period),
      .window (window),
      .timeout(timeout)
   );

   wkc_start_matcher #(.PW(PW)) u_match (
      .clk    (clk),
      .rst_n  (rst_n),
      .flush  (flush),
      .shift  (shift),
      .bit_in (det_in),
      .pattern(pattern),
      .hit    (hit),
      .fill   (fill)
   );

   always_comb begin
      mon       = (state_q == MODE_MON);
      in_win    = (pos_q < window);
      at_sample = (window != '0) && (pos_q == window - ONE);
      wrap      = (pos_q >= period - ONE);
      shift     = mon && !force_id && tick && at_sample;
      flush     = force_id || !mon;
      expire    = tick && (tcnt_q >= timeout - ONE);
      leave     = !mon && (dec_done || dec_fail || expire);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= MODE_MON;
         pos_q   <= '0;
         tcnt_q  <= '0;
      end else if (force_id) begin
         state_q <= MODE_MON;
         pos_q   <= '0;
         tcnt_q  <= '0;
      end else if (mon) begin
         if (hit) begin
            state_q <= MODE_ID;
            tcnt_q  <= '0;
         end else if (tick) begin
            pos_q <= wrap ? '0 : pos_q + ONE;
         end
      end else begin
         if (leave) begin
            state_q <= MODE_MON;
            pos_q   <= '0;
            tcnt_q  <= '0;
         end else if (tick) begin
            tcnt_q <= tcnt_q + ONE;
         end
      end
   end

   assign fe_en  = force_id || !mon || in_win;
   assign dec_en = force_id || !mon;
endmodule

// File: rtl/wkc_dutycycle_chk.sv
module wkc_dutycycle_chk #(
   parameter int PW = 8
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    force_id,
   input logic                    dec_done,
   input logic                    dec_fail,
   input logic                    fe_en,
   input logic                    dec_en,
   input logic [$clog2(PW+1)-1:0] fill
);
   assert_id_powered_R5: assert property (@(posedge clk) disable iff (!rst_n)
      dec_en |-> fe_en);

   assert_force_outputs_R9: assert property (@(posedge clk) disable iff (!rst_n)
      force_id |-> (fe_en && dec_en));

   assert_result_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_en && !force_id && (dec_done || dec_fail)) |=> (!dec_en || force_id));

   assert_enter_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(dec_en) && !force_id) |-> $past(fe_en));

   assert_fill_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= ($clog2(PW+1))'(PW));
endmodule

bind wkc_dutycycle_ctrl wkc_dutycycle_chk #(.PW(PW)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .force_id(force_id),
   .dec_done(dec_done),
   .dec_fail(dec_fail),
   .fe_en   (fe_en),
   .dec_en  (dec_en),
   .fill    (fill)
);

// File: tb/sim_wkc_dutycycle_ctrl.sv
module sim_wkc_dutycycle_ctrl;
   localparam int DIV = 4;
   localparam int TW  = 16;
   localparam int PER = 8;
   localparam int WIN = 2;
   localparam int TO  = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic force_id = 1'b0, det_in = 1'b0, dec_done = 1'b0, dec_fail = 1'b0;
   logic cfg_we = 1'b0;
   logic [1:0] cfg_addr = '0;
   logic [TW-1:0] cfg_wdata = '0;
   logic fe_en, dec_en;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   typedef struct {
      int width;
      int interval;
   } pulse_t;
   pulse_t exp_q[$];

   always #2.5 clk = ~clk;

   wkc_dutycycle_ctrl #(.TICK_DIV(DIV), .TW(TW)) u0 (
      .clk(clk), .rst_n(rst_n), .force_id(force_id), .det_in(det_in),
      .dec_done(dec_done), .dec_fail(dec_fail), .cfg_we(cfg_we),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .fe_en(fe_en), .dec_en(dec_en)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // monitor: measures monitoring-mode pulses and pops expected ones
   int cyc = 0, rise_cyc = 0, last_rise = 0, interval = 0;
   logic prev_fe = 1'b0;
   always @(negedge clk) begin
      cyc++;
      if (rst_n && !dec_en && !force_id) begin
         if (fe_en && !prev_fe) begin
            interval  = cyc - last_rise;
            last_rise = cyc;
            rise_cyc  = cyc;
         end else if (!fe_en && prev_fe && exp_q.size() > 0) begin
            pulse_t e;
            e = exp_q.pop_front();
            check((cyc - rise_cyc) == e.width, "R2 width", cyc - rise_cyc, e.width);
            check(interval == e.interval, "R2 period", interval, e.interval);
         end
      end
      prev_fe = fe_en;
   end

   task automatic cfg_write(input logic [1:0] a, input int d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = TW'(d);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic send_bit(input logic b);
      while (!fe_en) @(negedge clk);
      det_in = b;
      do @(negedge clk); while (fe_en && !dec_en);
      det_in = ~b;   // outside the window: must be ignored
   endtask

   task automatic send_bits(input logic [7:0] v, input int n);
      for (int i = n - 1; i >= 0; i--) begin
         send_bit(v[i]);
         if (dec_en) break;
      end
   endtask

   task automatic pulse_force();
      @(negedge clk); force_id = 1'b1;
      @(negedge clk); force_id = 1'b0;
   endtask

   task automatic result_pulse(input bit fail, input string req);
      repeat (3) @(negedge clk);
      if (fail) dec_fail = 1'b1; else dec_done = 1'b1;
      @(negedge clk);
      dec_done = 1'b0; dec_fail = 1'b0;
      check(dec_en == 1'b0, req, dec_en, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(dec_en == 1'b0, "R1 dec_en in reset", dec_en, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(fe_en == 1'b1, "R1 window at start", fe_en, 1);
      check(dec_en == 1'b0, "R1 dec_en after reset", dec_en, 0);

      // R10: shrink timing values
      cfg_write(2'd1, PER);
      cfg_write(2'd2, WIN);
      cfg_write(2'd3, TO);
      repeat (2 * PER * DIV) @(negedge clk);
      while (fe_en) @(negedge clk);
      for (int k = 0; k < 3; k++) exp_q.push_back('{WIN * DIV, PER * DIV});
      while (exp_q.size() > 0) @(negedge clk);

      // R11: wrong sequence
      send_bits(8'h53, 8);
      check(dec_en == 1'b0, "R11 wrong pattern", dec_en, 0);

      // R3/R4: default pattern 8'hAC, first bit vs pattern bit 7
      send_bits(8'hAC, 8);
      check(dec_en == 1'b1, "R4 match enters id", dec_en, 1);
      check(fe_en == 1'b1, "R3 R5 front end held", fe_en, 1);

      // R6: timeout length, restart with window
      begin
         int hi = 0;
         while (dec_en) begin hi++; @(negedge clk); end
         check(hi == TO * DIV, "R6 timeout cycles", hi, TO * DIV);
         check(fe_en == 1'b1, "R6 window restarts", fe_en, 1);
      end

      // R8: history flushed, 7 bits do not complete old pattern
      send_bits(8'hAC, 7);
      check(dec_en == 1'b0, "R8 flush after exit", dec_en, 0);
      send_bits(8'hAC, 8);
      check(dec_en == 1'b1, "R8 fresh match", dec_en, 1);
      result_pulse(1'b0, "R7 done exit");

      // R10: new pattern
      pulse_force();
      cfg_write(2'd0, 8'h5A);
      pulse_force();
      send_bits(8'h5A, 8);
      check(dec_en == 1'b1, "R10 new pattern match", dec_en, 1);
      result_pulse(1'b1, "R7 fail exit");

      // R8: all-zero pattern still needs 8 fresh samples
      cfg_write(2'd0, 0);
      pulse_force();
      send_bits(8'h00, 7);
      check(dec_en == 1'b0, "R8 zero pattern 7 samples", dec_en, 0);
      send_bits(8'h00, 1);
      check(dec_en == 1'b1, "R8 zero pattern 8 samples", dec_en, 1);
      result_pulse(1'b0, "R7 done exit 2");

      // R9: force longer than timeout
      @(negedge clk);
      force_id = 1'b1;
      begin
         int bad = 0;
         for (int k = 0; k < 2 * TO * DIV; k++) begin
            #1;
            if (!(fe_en && dec_en)) bad++;
            @(negedge clk);
         end
         check(bad == 0, "R9 forced outputs", bad, 0);
      end
      force_id = 1'b0;
      #1;
      check(dec_en == 1'b0, "R9 release", dec_en, 0);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule